// File: doc/BRIEF.md
# Status Pin Function Multiplexer

This block drives the single multi-purpose status pin of a two-loop frequency synthesizer. Four mode bits decide what the pin carries. Two of them are lock-monitor bits, one per loop, and two are divider-monitor bits, one per loop. The pin can be held low, report lock for one loop or for both, mirror one loop's reference or feedback divider pulse, or act as the open-drain switch that adds a second damping resistor while a loop is in fast lock. In the remaining mode codes the pin sits low, and the block asks one loop or both to clear their dividers and float their charge pumps.

Loop A is index 0 of every per-loop vector and loop B is index 1. A loop counts as locked in a cycle when its phase detector drives neither its up pulse nor its down pulse. All outputs are registered, so each output follows the inputs sampled at the previous rising clock edge. The analog pad driver and the loop filters sit outside this block.

Top module: `status_pin_mux`

## Requirements
- R1: While rst_n is low, pin_out, pin_od_en, cnt_rst and cp_tri are all 0.
- R2: Outputs are registered. A change at the inputs appears at the outputs one rising clock edge later.
- R3: With dv_sel = 2'b00 and lk_sel = 2'b00, the pin is disabled and pin_out is 0.
- R4: With dv_sel = 2'b00 and exactly one bit of lk_sel set, pin_out shows the lock state of the loop whose bit is set. The lock state is !(pd_up[i] | pd_dn[i]).
- R5: With dv_sel = 2'b00 and lk_sel = 2'b11, pin_out is 1 only when both loops are locked.
- R6: With exactly one bit of dv_sel set, that bit picks the loop and lk_sel[1] picks the signal. When lk_sel[1] is 0, pin_out is the loop's ref_pls. When it is 1, pin_out is the loop's fb_pls. lk_sel[0] has no effect in these modes.
- R7: With dv_sel = 2'b11 and lk_sel = 2'b00 (fast-lock), pin_out is 0 and pin_od_en equals fast_cur.
- R8: In every mode other than fast-lock, pin_od_en is 0.
- R9: With dv_sel = 2'b11, cnt_rst equals lk_sel: bit 0 clears loop A and bit 1 clears loop B. In these modes pin_out is 0. In all other modes cnt_rst is 0.
- R10: cp_tri equals cnt_rst in every mode, so each loop being cleared also has its charge pump floated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_sel | input | 2 | Lock-monitor mode bits, [0] loop A, [1] loop B |
| dv_sel | input | 2 | Divider-monitor mode bits, [0] loop A, [1] loop B |
| pd_up | input | 2 | Phase detector up pulse per loop |
| pd_dn | input | 2 | Phase detector down pulse per loop |
| ref_pls | input | 2 | Reference divider output pulse per loop |
| fb_pls | input | 2 | Feedback divider output pulse per loop |
| fast_cur | input | 1 | Loop A high-current (fast-lock) bit |
| pin_out | output | 1 | Push-pull data for the status pin |
| pin_od_en | output | 1 | Open-drain pull-to-ground enable for the status pin |
| cnt_rst | output | 2 | Per-loop divider clear request |
| cp_tri | output | 2 | Per-loop charge-pump tristate request |

## Verification
A wrong decode shows on the ports one edge after the mode bits are applied. It appears as the wrong source on pin_out, as a stray pull-down on pin_od_en, or as the wrong loop being cleared or floated. Swapping the loops, or swapping the reference and feedback signals, only becomes visible when the two candidate signals differ. For that reason the bench applies every combination of the nine data inputs under each of the sixteen mode codes. A bad lock combine shows up as soon as one loop has a pending pulse while the other is quiet.

// File: rtl/pin_mux_pkg.sv
package pin_mux_pkg;

  localparam int LOOPS = 2;
  localparam int LOOP_A = 0;
  localparam int LOOP_B = 1;

  typedef enum logic [3:0] {
    FN_OFF,
    FN_LOCK_A,
    FN_LOCK_B,
    FN_LOCK_AB,
    FN_REF_A,
    FN_REF_B,
    FN_FB_A,
    FN_FB_B,
    FN_FAST,
    FN_CLR_A,
    FN_CLR_B,
    FN_CLR_AB
  } pin_fn_e;

  // Map the four mode bits onto one pin function.
  function automatic pin_fn_e decode_fn(input logic [1:0] lk, input logic [1:0] dv);
    pin_fn_e f;
    unique case (dv)
      2'b00: begin
        unique case (lk)
          2'b00:   f = FN_OFF;
          2'b01:   f = FN_LOCK_A;
          2'b10:   f = FN_LOCK_B;
          default: f = FN_LOCK_AB;
        endcase
      end
      2'b01:   f = lk[LOOP_B] ? FN_FB_A : FN_REF_A;
      2'b10:   f = lk[LOOP_B] ? FN_FB_B : FN_REF_B;
      default: begin
        unique case (lk)
          2'b00:   f = FN_FAST;
          2'b01:   f = FN_CLR_A;
          2'b10:   f = FN_CLR_B;
          default: f = FN_CLR_AB;
        endcase
      end
    endcase
    return f;
  endfunction

  function automatic logic is_clear(input pin_fn_e f);
    return (f == FN_CLR_A) || (f == FN_CLR_B) || (f == FN_CLR_AB);
  endfunction

endpackage

// File: rtl/pmx_lock_det.sv
module pmx_lock_det
  import pin_mux_pkg::*;
(
  input  logic [LOOPS-1:0] up,
  input  logic [LOOPS-1:0] dn,
  output logic [LOOPS-1:0] locked,
  output logic             all_locked
);
  for (genvar i = 0; i < LOOPS; i++) begin : g_loop
    assign locked[i] = ~(up[i] | dn[i]);
  end
  assign all_locked = &locked;
endmodule

// File: rtl/pmx_decode.sv
module pmx_decode
  import pin_mux_pkg::*;
(
  input  logic [1:0]       lk_sel,
  input  logic [1:0]       dv_sel,
  output pin_fn_e          fn,
  output logic [LOOPS-1:0] clr_req
);
  assign fn = decode_fn(lk_sel, dv_sel);

  always_comb begin
    clr_req = '0;
    unique case (fn)
      FN_CLR_A:  clr_req[LOOP_A] = 1'b1;
      FN_CLR_B:  clr_req[LOOP_B] = 1'b1;
      FN_CLR_AB: clr_req = '1;
      default:   clr_req = '0;
    endcase
  end
endmodule

// File: rtl/pmx_source_sel.sv
module pmx_source_sel
  import pin_mux_pkg::*;
(
  input  pin_fn_e          fn,
  input  logic [LOOPS-1:0] locked,
  input  logic             all_locked,
  input  logic [LOOPS-1:0] ref_pls,
  input  logic [LOOPS-1:0] fb_pls,
  input  logic             fast_cur,
  output logic             pin_d,
  output logic             od_d
);
  always_comb begin
    pin_d = 1'b0;
    od_d  = 1'b0;
    unique case (fn)
      FN_LOCK_A:  pin_d = locked[LOOP_A];
      FN_LOCK_B:  pin_d = locked[LOOP_B];
      FN_LOCK_AB: pin_d = all_locked;
      FN_REF_A:   pin_d = ref_pls[LOOP_A];
      FN_REF_B:   pin_d = ref_pls[LOOP_B];
      FN_FB_A:    pin_d = fb_pls[LOOP_A];
      FN_FB_B:    pin_d = fb_pls[LOOP_B];
      FN_FAST:    od_d  = fast_cur;
      default:    pin_d = 1'b0;
    endcase
  end
endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
  import pin_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lk_sel,
  input  logic [1:0] dv_sel,
  input  logic [1:0] pd_up,
  input  logic [1:0] pd_dn,
  input  logic [1:0] ref_pls,
  input  logic [1:0] fb_pls,
  input  logic       fast_cur,
  output logic       pin_out,
  output logic       pin_od_en,
  output logic [1:0] cnt_rst,
  output logic [1:0] cp_tri
);
  pin_fn_e          fn;
  logic [LOOPS-1:0] clr_req;
  logic [LOOPS-1:0] locked;
  logic             all_locked;
  logic             pin_d;
  logic             od_d;

  pmx_decode u_dec (
    .lk_sel (lk_sel),
    .dv_sel (dv_sel),
    .fn     (fn),
    .clr_req(clr_req)
  );

  pmx_lock_det u_lock (
    .up        (pd_up),
    .dn        (pd_dn),
    .locked    (locked),
    .all_locked(all_locked)
  );

  pmx_source_sel u_sel (
    .fn        (fn),
    .locked    (locked),
    .all_locked(all_locked),
    .ref_pls   (ref_pls),
    .fb_pls    (fb_pls),
    .fast_cur  (fast_cur),
    .pin_d     (pin_d),
    .od_d      (od_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out   <= 1'b0;
      pin_od_en <= 1'b0;
      cnt_rst   <= '0;
      cp_tri    <= '0;
    end else begin
      pin_out   <= pin_d;
      pin_od_en <= od_d;
      cnt_rst   <= clr_req;
      cp_tri    <= clr_req;
    end
  end

  // R3
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_OFF) |=> !pin_out);

  // R5
  pair_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_LOCK_AB && ((|pd_up) || (|pd_dn))) |=> !pin_out);

  // R7
  fast_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_FAST) |=> (!pin_out && pin_od_en == $past(fast_cur)));

  // R8
  od_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn != FN_FAST) |=> !pin_od_en);

  // R9
  clr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_clear(fn) |=> (!pin_out && cnt_rst == $past(lk_sel)));

  // R10
  tri_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cnt_rst) == $countones(cp_tri));

endmodule

// File: tb/test_status_pin_mux.sv
`timescale 1ns/1ps
module test_status_pin_mux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lk_sel = '0, dv_sel = '0, pd_up = '0, pd_dn = '0, ref_pls = '0, fb_pls = '0;
  logic       fast_cur = 1'b0;
  logic       pin_out, pin_od_en;
  logic [1:0] cnt_rst, cp_tri;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  status_pin_mux i_status_pin_mux (
    .clk(clk), .rst_n(rst_n), .lk_sel(lk_sel), .dv_sel(dv_sel),
    .pd_up(pd_up), .pd_dn(pd_dn), .ref_pls(ref_pls), .fb_pls(fb_pls),
    .fast_cur(fast_cur), .pin_out(pin_out), .pin_od_en(pin_od_en),
    .cnt_rst(cnt_rst), .cp_tri(cp_tri)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: mode lk=%b dv=%b actual=%b expected=%b", req, lk_sel, dv_sel, act, exp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic       lka, lkb, exp_pin, exp_od;
    logic [1:0] exp_clr;
    string      tag;

    // R1: hold reset with every input active
    lk_sel = 2'b01; dv_sel = 2'b01; ref_pls = 2'b11; fb_pls = 2'b11; fast_cur = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pin", {1'b0, pin_out}, 2'b00);
    check("R1 od", {1'b0, pin_od_en}, 2'b00);
    check("R1 clr", cnt_rst, 2'b00);
    check("R1 tri", cp_tri, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: a change is not visible until the next edge
    @(negedge clk);
    lk_sel = 2'b00; dv_sel = 2'b11; fast_cur = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    dv_sel = 2'b00;
    #1;
    check("R2 hold", {1'b0, pin_od_en}, 2'b01);
    @(posedge clk); #1;
    check("R2 update", {1'b0, pin_od_en}, 2'b00);

    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 512; p++) begin
        @(negedge clk);
        lk_sel   = m[1:0];
        dv_sel   = m[3:2];
        pd_up    = p[1:0];
        pd_dn    = p[3:2];
        ref_pls  = p[5:4];
        fb_pls   = p[7:6];
        fast_cur = p[8];
        lka = !(pd_up[0] || pd_dn[0]);
        lkb = !(pd_up[1] || pd_dn[1]);
        exp_pin = 1'b0; exp_od = 1'b0; exp_clr = 2'b00;
        if (dv_sel == 2'b00) begin
          if (lk_sel == 2'b00)      begin exp_pin = 1'b0;      tag = "R3"; end
          else if (lk_sel == 2'b01) begin exp_pin = lka;       tag = "R4"; end
          else if (lk_sel == 2'b10) begin exp_pin = lkb;       tag = "R4"; end
          else                      begin exp_pin = lka & lkb; tag = "R5"; end
        end else if (dv_sel != 2'b11) begin
          exp_pin = lk_sel[1] ? fb_pls[dv_sel[1]] : ref_pls[dv_sel[1]];
          tag = "R6";
        end else begin
          exp_clr = lk_sel;
          exp_od  = (lk_sel == 2'b00) && fast_cur;
          tag = (lk_sel == 2'b00) ? "R7" : "R9";
        end
        @(posedge clk); #1;
        check({tag, " pin"}, {1'b0, pin_out}, {1'b0, exp_pin});
        check((dv_sel == 2'b11 && lk_sel == 2'b00) ? "R7 od" : "R8 od",
              {1'b0, pin_od_en}, {1'b0, exp_od});
        check("R9 clr", cnt_rst, exp_clr);
        check("R10 tri", cp_tri, exp_clr);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule